// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the serial interface and control logic of a small three-wire EEPROM. The array is a set of on-chip registers. A host selects the device with a chip-select line and clocks commands in on a serial data input. Each command is a start bit of 1, a two-bit opcode and an address, both sent most significant bit first. A WRITE command is followed by a data word. A read returns data on a serial output that has its own output-enable, so the pin can be tri-stated at the pad.

All pins are sampled in the system clock domain. A serial-clock rising edge counts only while chip select is high. A read places a single zero on the output, then streams words from consecutive addresses for as long as the host keeps clocking, and wraps from the top address back to zero. A write-enable latch comes up clear and guards every change to the array. Programming takes effect in one clock. A parameter selects 16-bit or 8-bit words and sizes the address to match.

Top module: `mwire_eeprom`

## Requirements
- R1: After reset, `sdo_oe` is low, the write-enable latch is clear, and every word of the array reads as all ones.
- R2: `sdi` is sampled on each rising edge of `sclk` while `chip_sel` is high. Zeros before the first 1 are skipped. That 1 is the start bit, followed by a 2-bit opcode and then the address, each most significant bit first.
- R3: On READ (opcode 10), `sdo_oe` goes high after the last address bit and `sdo` carries one 0. Each later `sclk` rise then presents the next bit of the addressed word, starting from the MSB.
- R4: While `chip_sel` stays high and `sclk` keeps toggling, the word at the next address follows directly after the LSB, with no zero bit between words.
- R5: The sequential read address wraps from the highest address to address 0.
- R6: Opcode 00 with the top two address-field bits at 11 sets the write-enable latch. With those bits at 00 it clears the latch. The lower address bits are don't-care.
- R7: WRITE (opcode 01) takes an address and then one data word, MSB first. When the latch is set, the word is stored as soon as its last bit arrives.
- R8: ERASE (opcode 11) with the latch set sets the addressed word to all ones after the last address bit.
- R9: While the latch is clear, WRITE and ERASE leave the array unchanged.
- R10: Driving `chip_sel` low aborts any command. `sdo_oe` falls on the next clock, and a WRITE that did not finish stores nothing.
- R11: `sdo` changes only in the clock after a qualified `sclk` rising edge.
- R12: READ returns stored data whether the latch is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command, address and data input |
| sdo | output | 1 | Serial read data output |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The checker watches, on every cycle, the rules that depend on timing alone. It checks that the output tri-states one clock after deselect and that `sdo` and the latch move only after a qualified serial edge. It also checks that each read opens with a zero and that no array write happens while a read stream is driving. Data content needs the bench scenarios: writes read back in the right bit order, sequential streaming across words and over the top address, erase, commands ignored while the latch is clear, skipped leading zeros, and aborted commands.

// File: rtl/mwire_pkg.sv
package mwire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_ENABLE  = 2'b11;
  localparam logic [1:0] SUB_DISABLE = 2'b00;
endpackage

// File: rtl/mwire_cmd_decoder.sv
module mwire_cmd_decoder
  import mwire_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              rd_start_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wen_o
);
  localparam int MAXLEN = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  mw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr_sr;
  logic [WORD_W-1:0] data_sr;
  logic              wen;

  logic [ADDR_W-1:0] full_addr;
  logic [WORD_W-1:0] full_data;
  logic              last_addr, last_data;
  logic [1:0]        sub;

  assign full_addr = {addr_sr[ADDR_W-2:0], bit_in};
  assign full_data = {data_sr[WORD_W-2:0], bit_in};
  assign last_addr = (state == ST_ADDR) && (cnt == CNT_W'(ADDR_W - 1));
  assign last_data = (state == ST_DATA) && (cnt == CNT_W'(WORD_W - 1));
  assign sub       = full_addr[ADDR_W-1 -: 2];

  always_comb begin
    mem_we_o = 1'b0;
    if (sel && bit_stb && wen) begin
      if (last_addr && op == OP_ERASE) mem_we_o = 1'b1;
      if (last_data && op == OP_WRITE) mem_we_o = 1'b1;
    end
  end

  assign mem_waddr_o = (state == ST_ADDR) ? full_addr : addr_sr;
  assign mem_wdata_o = (state == ST_DATA) ? full_data : '1;
  assign rd_start_o  = sel && bit_stb && last_addr && (op == OP_READ);
  assign rd_addr_o   = full_addr;
  assign wen_o       = wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op      <= '0;
      addr_sr <= '0;
      data_sr <= '0;
      wen     <= 1'b0;
    end else if (!sel) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (bit_stb) begin
      case (state)
        ST_IDLE: if (bit_in) begin
          state <= ST_OPC;
          cnt   <= '0;
        end
        ST_OPC: begin
          op  <= {op[0], bit_in};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(1)) begin
            state <= ST_ADDR;
            cnt   <= '0;
          end
        end
        ST_ADDR: begin
          addr_sr <= full_addr;
          cnt     <= cnt + 1'b1;
          if (last_addr) begin
            cnt <= '0;
            case (op)
              OP_READ:  state <= ST_READ;
              OP_WRITE: state <= ST_DATA;
              OP_ERASE: state <= ST_HOLD;
              default: begin
                state <= ST_HOLD;
                if (sub == SUB_ENABLE)  wen <= 1'b1;
                if (sub == SUB_DISABLE) wen <= 1'b0;
              end
            endcase
          end
        end
        ST_DATA: begin
          data_sr <= full_data;
          cnt     <= cnt + 1'b1;
          if (last_data) state <= ST_HOLD;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/mwire_word_array.sv
module mwire_word_array #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= '1;
      else if (we && waddr == ADDR_W'(g))     mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mwire_rd_stream.sv
module mwire_rd_stream #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              bit_stb,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] fetch_word,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int BC_W = $clog2(WORD_W);

  logic              active;
  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] sh;
  logic [BC_W-1:0]   bcnt;
  logic              sdo_r;

  assign fetch_addr = rd_start ? start_addr : ptr + 1'b1;
  assign sdo        = sdo_r;
  assign sdo_oe     = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
      sh     <= '0;
      bcnt   <= '0;
      sdo_r  <= 1'b0;
    end else if (!sel) begin
      active <= 1'b0;
    end else if (rd_start) begin
      active <= 1'b1;
      ptr    <= start_addr;
      sh     <= fetch_word;
      bcnt   <= '0;
      sdo_r  <= 1'b0;
    end else if (active && bit_stb) begin
      sdo_r <= sh[WORD_W-1];
      if (bcnt == BC_W'(WORD_W - 1)) begin
        ptr  <= ptr + 1'b1;
        sh   <= fetch_word;
        bcnt <= '0;
      end else begin
        sh   <= {sh[WORD_W-2:0], 1'b0};
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom #(
  parameter bit ORG16      = 1'b1,
  parameter int TOTAL_BITS = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int WORD_W = ORG16 ? 16 : 8;
  localparam int ADDR_W = $clog2(TOTAL_BITS / WORD_W);

  logic              sclk_q;
  logic              bit_stb;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;
  logic              rd_start;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] fetch_addr;
  logic [WORD_W-1:0] fetch_word;
  logic              wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign bit_stb = chip_sel && sclk && !sclk_q;

  mwire_cmd_decoder #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (chip_sel),
    .bit_stb    (bit_stb),
    .bit_in     (sdi),
    .mem_we_o   (mem_we),
    .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata),
    .rd_start_o (rd_start),
    .rd_addr_o  (rd_addr),
    .wen_o      (wen)
  );

  mwire_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(fetch_addr),
    .rdata(fetch_word)
  );

  mwire_rd_stream #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (chip_sel),
    .bit_stb   (bit_stb),
    .rd_start  (rd_start),
    .start_addr(rd_addr),
    .fetch_word(fetch_word),
    .fetch_addr(fetch_addr),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );
endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_sel,
  input logic bit_stb,
  input logic sdo,
  input logic sdo_oe,
  input logic wen,
  input logic mem_we
);
  p_hiz_on_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !sdo_oe);

  p_out_moves_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(sdo));

  p_dummy_zero_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  p_latch_moves_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(wen));

  p_no_write_in_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !sdo_oe);
endmodule

bind mwire_eeprom mwire_eeprom_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .chip_sel(chip_sel),
  .bit_stb (bit_stb),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .wen     (wen),
  .mem_we  (mem_we)
);

// File: tb/mwire_eeprom_tb_top.sv
module mwire_eeprom_tb_top;
  localparam int WW = 16;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n, cs, sk, di;
  logic dout, doe;

  always #2 clk = ~clk;

  mwire_eeprom dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel(cs), .sclk(sk), .sdi(di),
    .sdo(dout), .sdo_oe(doe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int r11_bad = 0;
  logic cap_d, cap_oe;
  logic [WW-1:0] shadow [1 << AW];

  // table entries: {address, data}
  localparam logic [AW+WW-1:0] VEC [6] = '{
    {7'd10,  16'h1111}, {7'd11, 16'h2222}, {7'd12, 16'hBEEF},
    {7'd127, 16'h7F7F}, {7'd0,  16'hC001}, {7'd64, 16'h0F0F}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel_on();
    @(negedge clk); sk = 1'b0; cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk); sk = 1'b0; cs = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    logic low_val;
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk); low_val = dout;
    @(negedge clk); sk = 1'b1;
    if (low_val !== dout) r11_bad++;
    @(negedge clk);
    @(negedge clk); cap_d = dout; cap_oe = doe;
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op, input logic [AW-1:0] a);
    for (int i = 0; i < pre; i++) clk_bit(1'b0);
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic do_special(input logic [AW-1:0] a);
    sel_on(); send_hdr(0, 2'b00, a); sel_off();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [WW-1:0] d);
    sel_on(); send_hdr(0, 2'b01, a);
    for (int i = WW - 1; i >= 0; i--) clk_bit(d[i]);
    sel_off();
  endtask

  task automatic do_erase(input logic [AW-1:0] a);
    sel_on(); send_hdr(0, 2'b11, a); sel_off();
  endtask

  task automatic read_seq(input int pre, input logic [AW-1:0] a, input int n, input string tag);
    logic [WW-1:0] word;
    logic [AW-1:0] idx;
    sel_on();
    send_hdr(pre, 2'b10, a);
    chk(cap_oe === 1'b1 && cap_d === 1'b0, "R3 dummy bit", {cap_oe, cap_d}, 2'b10);
    for (int w = 0; w < n; w++) begin
      word = '0;
      for (int b = 0; b < WW; b++) begin
        clk_bit(1'b0);
        word = {word[WW-2:0], cap_d};
      end
      idx = a + AW'(w);
      chk(word === shadow[idx], tag, word, shadow[idx]);
    end
    sel_off();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(doe === 1'b0, "R1 oe after reset", doe, 0);
    read_seq(0, 7'd5, 1, "R1 erased after reset");

    // latch clear after reset: write is dropped
    do_write(7'd3, 16'h1234);
    read_seq(0, 7'd3, 1, "R9 write while disabled");

    // enable with non-zero low bits
    do_special(7'b1110101);

    // table: write then read back (R7)
    for (int k = 0; k < 6; k++) begin
      do_write(VEC[k][AW+WW-1:WW], VEC[k][WW-1:0]);
      shadow[VEC[k][AW+WW-1:WW]] = VEC[k][WW-1:0];
      read_seq(0, VEC[k][AW+WW-1:WW], 1, "R7 write readback");
    end

    read_seq(0, 7'd10, 3, "R4 sequential read");
    read_seq(0, 7'd127, 3, "R5 wrap to zero");
    read_seq(3, 7'd64, 1, "R2 leading zeros");

    do_erase(7'd12);
    shadow[12] = '1;
    read_seq(0, 7'd12, 1, "R8 erase");

    // disable with non-zero low bits, then attempts are ignored
    do_special(7'b0011111);
    do_write(7'd11, 16'h9999);
    do_erase(7'd10);
    read_seq(0, 7'd10, 2, "R6 disable blocks write and erase");
    read_seq(0, 7'd64, 1, "R12 read while disabled");

    // aborted write
    do_special(7'b1100000);
    sel_on(); send_hdr(0, 2'b01, 7'd64);
    for (int i = 0; i < 8; i++) clk_bit(1'b0);
    sel_off();
    read_seq(0, 7'd64, 1, "R10 aborted write");

    // aborted read
    sel_on(); send_hdr(0, 2'b10, 7'd0);
    for (int i = 0; i < 5; i++) clk_bit(1'b1);
    chk(cap_oe === 1'b1, "R10 oe during read", cap_oe, 1);
    sel_off();
    chk(doe === 1'b0, "R10 oe after deselect", doe, 0);
    read_seq(0, 7'd0, 1, "R10 read after abort");

    chk(r11_bad == 0, "R11 output held between edges", r11_bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule